// File: doc/BRIEF.md
# Bit-Addressable Latch with Decode Mode

This block holds a bank of single-bit storage entries, eight by default. A binary select picks one entry, and a serial data bit can be written into it. Every entry drives its own active-high parallel output. Two active-low control inputs, a clear line and an enable line, are read together as a 2-bit mode code. The code picks one of four behaviours: write one entry, hold everything, decode the data bit onto the selected output, or zero all outputs.

The design is a clocked version of a level-sensitive addressable latch. Every mode takes effect at the rising clock edge. The outputs come straight from the storage flops. In write mode, the entry is chosen by the select value captured at the last edge that was not in write mode. Because of this, a select that changes or glitches during a write cannot disturb the wrong entry. Typical uses are serial-to-parallel loading, one bit per cycle, and one-hot strobe generation from a binary code.

Top module: `addr_latch_demux`

## Requirements
- R1: Write mode is `clr_n`=1 with `en_n`=0. At each rising edge in this mode, the target entry takes the value of `din`, and every other output bit keeps its value.
- R2: Hold mode is `clr_n`=1 with `en_n`=1. At each rising edge in this mode, all outputs keep their values, whatever `sel` and `din` do.
- R3: Decode mode is `clr_n`=0 with `en_n`=0. At each rising edge in this mode, `q[sel]` takes `din`, and all other output bits become 0. The select used is the value present at that edge.
- R4: Zero mode is `clr_n`=0 with `en_n`=1. At each rising edge in this mode, all output bits become 0, whatever `sel` and `din` are.
- R5: `sel` is unsigned binary with bit 0 as its least significant bit. Select value k refers to output bit `q[k]`.
- R6: In write mode, the target entry is the `sel` value sampled at the most recent rising edge that was not in write mode. The captured value is 0 after reset. Changes of `sel` during write mode do not change which entry is written.
- R7: The storage follows the decoded pattern. After a decode-mode edge, hold mode keeps exactly that one-hot-or-zero pattern on `q`.
- R8: When `rst` is 1 at a rising edge, all outputs become 0 and the captured select becomes 0, regardless of mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clr_n | input | 1 | Active-low clear control, forms mode code bit 1 |
| en_n | input | 1 | Active-low enable control, forms mode code bit 0 |
| sel | input | AW (3) | Binary entry select |
| din | input | 1 | Serial data bit |
| q | output | 2**AW (8) | Registered parallel outputs, active high |

## Verification
On every cycle, the assertions check these mode effects: reset and zero mode give all zeros, hold mode leaves `q` stable, write mode changes at most one bit, and decode mode leaves at most one bit set, with the bit at the previous select equal to the previous data. Which entry a write lands on depends on the captured select, so only the bench's reference model can show this. It is checked by directed runs that move `sel` during write mode, and by long random mode sequences. The bench scenarios also cover how patterns carry over between modes, such as a decode result held and then partly overwritten.

// File: rtl/alatch_pkg.sv
package alatch_pkg;
  // Mode code is {clr_n, en_n}
  typedef enum logic [1:0] {
    M_DECODE = 2'b00,
    M_ZERO   = 2'b01,
    M_WRITE  = 2'b10,
    M_HOLD   = 2'b11
  } mode_e;

  function automatic mode_e to_mode(input logic clr_n, input logic en_n);
    return mode_e'({clr_n, en_n});
  endfunction
endpackage

// File: rtl/alatch_mode_dec.sv
module alatch_mode_dec
  import alatch_pkg::*;
(
  input  logic  clr_n,
  input  logic  en_n,
  output mode_e mode
);
  always_comb mode = to_mode(clr_n, en_n);
endmodule

// File: rtl/alatch_sel_guard.sv
module alatch_sel_guard
  import alatch_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  mode_e         mode,
  input  logic [AW-1:0] sel,
  output logic [AW-1:0] wr_sel
);
  logic [AW-1:0] cap_q;

  // The select is frozen for as long as write mode lasts
  always_ff @(posedge clk) begin
    if (rst)                  cap_q <= '0;
    else if (mode != M_WRITE) cap_q <= sel;
  end

  assign wr_sel = cap_q;
endmodule

// File: rtl/alatch_bank.sv
module alatch_bank
  import alatch_pkg::*;
#(
  parameter int AW = 3,
  localparam int N = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  mode_e         mode,
  input  logic [AW-1:0] wr_sel,
  input  logic [AW-1:0] live_sel,
  input  logic          din,
  output logic [N-1:0]  q
);
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_cell
      logic bit_q;
      logic bit_d;
      always_comb begin
        unique case (mode)
          M_WRITE:  bit_d = (wr_sel == AW'(i)) ? din : bit_q;
          M_HOLD:   bit_d = bit_q;
          M_DECODE: bit_d = (live_sel == AW'(i)) ? din : 1'b0;
          default:  bit_d = 1'b0;
        endcase
      end
      always_ff @(posedge clk) begin
        if (rst) bit_q <= 1'b0;
        else     bit_q <= bit_d;
      end
      assign q[i] = bit_q;
    end
  endgenerate
endmodule

// File: rtl/addr_latch_demux.sv
module addr_latch_demux
  import alatch_pkg::*;
#(
  parameter int AW = 3,
  localparam int N = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_n,
  input  logic          en_n,
  input  logic [AW-1:0] sel,
  input  logic          din,
  output logic [N-1:0]  q
);
  mode_e         mode;
  logic [AW-1:0] wr_sel;

  alatch_mode_dec u_dec (
    .clr_n (clr_n),
    .en_n  (en_n),
    .mode  (mode)
  );

  alatch_sel_guard #(.AW(AW)) u_guard (
    .clk    (clk),
    .rst    (rst),
    .mode   (mode),
    .sel    (sel),
    .wr_sel (wr_sel)
  );

  alatch_bank #(.AW(AW)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .wr_sel   (wr_sel),
    .live_sel (sel),
    .din      (din),
    .q        (q)
  );
endmodule

// File: rtl/addr_latch_demux_chk.sv
module addr_latch_demux_chk #(
  parameter int AW = 3,
  localparam int N = 1 << AW
) (
  input logic          clk,
  input logic          rst,
  input logic          clr_n,
  input logic          en_n,
  input logic [AW-1:0] sel,
  input logic          din,
  input logic [N-1:0]  q
);
  logic armed;
  always_ff @(posedge clk) armed <= rst ? 1'b1 : armed;

  a_r8_reset_zero: assert property (@(posedge clk) rst |=> (q == '0));

  a_r4_zero_mode: assert property (@(posedge clk) disable iff (rst)
    (!clr_n && en_n) |=> (q == '0));

  a_r2_hold_stable: assert property (@(posedge clk) disable iff (rst || !armed)
    (clr_n && en_n) |=> $stable(q));

  a_r1_write_one_bit: assert property (@(posedge clk) disable iff (rst || !armed)
    (clr_n && !en_n) |=> ($countones(q ^ $past(q)) <= 1));

  a_r3_decode_onehot: assert property (@(posedge clk) disable iff (rst)
    (!clr_n && !en_n) |=> $onehot0(q));

  a_r5_decode_target: assert property (@(posedge clk) disable iff (rst)
    (!clr_n && !en_n) |=> (q[$past(sel)] == $past(din)));
endmodule

bind addr_latch_demux addr_latch_demux_chk #(.AW(AW)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .clr_n (clr_n),
  .en_n  (en_n),
  .sel   (sel),
  .din   (din),
  .q     (q)
);

// File: tb/sim_addr_latch_demux.sv
`timescale 1ns/1ps
module sim_addr_latch_demux;
  localparam int AW = 3;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clr_n = 1'b1;
  logic          en_n = 1'b1;
  logic [AW-1:0] sel = '0;
  logic          din = 1'b0;
  logic [N-1:0]  q;

  int n_cmp = 0;
  int n_bad = 0;
  logic [N-1:0]  mdl = '0;
  logic [AW-1:0] cap = '0;
  bit done = 0;

  always #5 clk = ~clk;

  addr_latch_demux #(.AW(AW)) u0 (
    .clk(clk), .rst(rst), .clr_n(clr_n), .en_n(en_n),
    .sel(sel), .din(din), .q(q)
  );

  function automatic logic [N-1:0] next_q(input logic [N-1:0] cur,
      input logic r, input logic c, input logic e,
      input logic [AW-1:0] s, input logic [AW-1:0] cp, input logic d);
    logic [N-1:0] nq;
    nq = cur;
    if (r) nq = '0;
    else case ({c, e})
      2'b10: nq[cp] = d;
      2'b11: nq = cur;
      2'b00: begin nq = '0; nq[s] = d; end
      default: nq = '0;
    endcase
    return nq;
  endfunction

  function automatic string tag(input logic r, input logic c, input logic e);
    if (r) return "R8";
    case ({c, e})
      2'b10: return "R1/R6";
      2'b11: return "R2/R7";
      2'b00: return "R3/R5";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string t, input logic [N-1:0] exp);
    n_cmp++;
    if (q !== exp) begin
      n_bad++;
      $display("FAIL %s: q=%b expected=%b", t, q, exp);
    end
  endtask

  // Drive one cycle, then compare after the edge
  task automatic step(input logic r, input logic c, input logic e,
                      input logic [AW-1:0] s, input logic d);
    string t;
    @(negedge clk);
    rst = r; clr_n = c; en_n = e; sel = s; din = d;
    t = tag(r, c, e);
    mdl = next_q(mdl, r, c, e, s, cap, d);
    if (r) cap = '0;
    else if (!(c && !e)) cap = s;
    @(posedge clk);
    #2;
    check(t, mdl);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    step(1, 1, 1, 0, 0);
    step(1, 0, 0, 3'd5, 1);
    check("R8 reset", '0);
    // R5/R6: capture select 2 in hold, then write while sel moves
    step(0, 1, 1, 3'd2, 0);
    step(0, 1, 0, 3'd5, 1);
    check("R6 captured target", 8'b0000_0100);
    step(0, 1, 0, 3'd7, 1);
    step(0, 1, 0, 3'd0, 1);
    check("R6 sel ignored in write", 8'b0000_0100);
    // R1: serial fill
    for (int k = 0; k < N; k++) begin
      step(0, 1, 1, 3'(k), 0);
      step(0, 1, 0, 3'(k), k[0]);
    end
    check("R1 serial load", 8'b1010_1010);
    // R2: hold ignores inputs
    step(0, 1, 1, 3'd1, 1);
    step(0, 1, 1, 3'd6, 0);
    check("R2 hold", 8'b1010_1010);
    // R3/R7: decode then hold
    step(0, 0, 0, 3'd6, 1);
    check("R3 decode", 8'b0100_0000);
    step(0, 1, 1, 3'd3, 1);
    check("R7 held decode", 8'b0100_0000);
    step(0, 0, 0, 3'd3, 0);
    check("R3 decode zero", '0);
    // R4
    step(0, 1, 1, 3'd4, 0);
    step(0, 1, 0, 3'd4, 1);
    step(0, 0, 1, 3'd4, 1);
    check("R4 zero", '0);
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] m;
      m = 2'($urandom % 4);
      step(($urandom % 97) == 0, m[1], m[0], AW'($urandom), 1'($urandom));
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule